// File: doc/BRIEF.md
# Programmable Read-Only Memory Device Model

This block is a clocked, synthesizable model of a one-time or light-erasable programmable byte memory, seen only from its control pins. Every pin is sampled on the rising clock edge, and the outputs are registered. Chip select, output gate and program strobe are all active low. Together with a "programming supply raised" flag, they pick one of six pin modes. Each mode decides whether the data outputs are driven, and whether a falling edge of the program strobe writes the addressed byte.

Programming can only clear bits. The stored byte becomes the old byte ANDed with the presented data. Only an erase brings bits back to 1. An erase request, or the release of reset, starts a sweep that writes all-ones into every location, one address per cycle, and a busy flag is raised for the length of the sweep.

A second flag stands for a raised voltage on one address line. When that flag is set and the address qualifies, a read returns one of two fixed identification bytes instead of array data. The full-size configuration is `ADDR_W = 13` (8192 bytes). The default is a smaller array so that elaboration stays light.

Top module: `eprom_model`

## Requirements
- R1: During reset, `busy` is 1 and `rd_oe`, `rd_data` and `prog_err` are 0. After reset is released, `busy` falls exactly DEPTH rising edges later, and every byte then reads 0xFF.
- R2: In program mode (`vpp_hi`=1, `ce_n`=0, `oe_n`=1), a falling edge of `pgm_n` stores `old & din` at `addr`. A 1 in `din` never sets a cleared bit.
- R3: Exactly one write happens per falling edge of `pgm_n`. While the strobe stays low, changes on `din` store nothing.
- R4: With `ce_n`=0, `oe_n`=0 and `pgm_n`=1, the outputs are driven one cycle later with the addressed byte. This holds with `vpp_hi` at 0 (read) and at 1 (verify).
- R5: With `ce_n`=1 (standby), `rd_oe` is 0 one cycle later, whatever `oe_n` does. Whenever `rd_oe` is 0, `rd_data` is 0.
- R6: With `ce_n`=0, `oe_n`=1 and `vpp_hi`=0 (output disable), `rd_oe` is 0 one cycle later.
- R7: With `vpp_hi`=1 and `ce_n`=1 (program inhibit), a strobe on `pgm_n` leaves the array unchanged.
- R8: Take a read with `id_hv`=1, `vpp_hi`=0, and every address bit other than bit 0 and bit ID_BIT at 0. It returns MFR_CODE (default 0x8F) when `addr[0]`=0, and DEV_CODE (default 0xC2) when `addr[0]`=1. If any of those other bits is 1, the array byte is returned instead.
- R9: A falling edge of `pgm_n` with `ce_n`=0 and `vpp_hi`=0 writes nothing, and pulses `prog_err` high for exactly one cycle, on the cycle after the edge.
- R10: When `erase_req` is 1 and the block is idle, `busy` rises on the next cycle and stays high for exactly DEPTH cycles. Every byte then reads 0xFF. Program strobes seen while `busy` is high are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every pin is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; starts an erase sweep |
| addr | input | ADDR_W | Byte address |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program strobe, active low, acts on its falling edge |
| din | input | DATA_W | Data presented for programming |
| vpp_hi | input | 1 | Programming supply is at its raised level |
| id_hv | input | 1 | Raised voltage present on address bit ID_BIT |
| erase_req | input | 1 | Request a full erase sweep |
| rd_data | output | DATA_W | Registered read data, 0 when not driven |
| rd_oe | output | 1 | Tri-state enable for `rd_data` |
| busy | output | 1 | Erase sweep in progress |
| prog_err | output | 1 | One-cycle pulse: strobe seen without programming supply |

## Verification
The assertions take the pins to be synchronous to `clk`, and `pgm_n` to be high while reset is asserted. They also take reads and program strobes to be kept away from an erase sweep, except where the stimulus deliberately strobes during one. The bench drives every pin on the falling clock edge. It holds `pgm_n` high through reset, and it waits for `busy` to fall before it starts a read sweep. The only strobe that overlaps a sweep targets an address the sweep has already passed, so an accepted write would remain visible afterwards.

// File: rtl/eprom_pkg.sv
// Package: shared pin-mode encoding for the programmable memory model.
// Assumes: consumers decode the six documented modes plus an illegal combination.
package eprom_pkg;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_READ,
        MD_DISABLE,
        MD_PROGRAM,
        MD_VERIFY,
        MD_INHIBIT,
        MD_ILLEGAL
    } eprom_mode_e;

    // True for the modes that drive the data outputs.
    function automatic logic mode_drives(eprom_mode_e m);
        return (m == MD_READ) || (m == MD_VERIFY);
    endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
// Module: eprom_mode_dec
// Decodes the control pins into a pin mode. It also flags when an
// identification byte replaces array data.
// Assumes: pins are already synchronous to the clock; purely combinational.
module eprom_mode_dec
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int ID_BIT = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic              vpp_hi,
    input  logic              id_hv,
    output eprom_mode_e       mode,
    output logic              drive,
    output logic              id_sel
);

    localparam logic [ADDR_W-1:0] QUAL_MASK =
        ~((ADDR_W'(1) << ID_BIT) | ADDR_W'(1));

    // Mode table: chip select first, then output gate, then strobe.
    always_comb begin
        if (ce_n) begin
            mode = vpp_hi ? MD_INHIBIT : MD_STANDBY;
        end else if (oe_n) begin
            mode = vpp_hi ? MD_PROGRAM : MD_DISABLE;
        end else if (!pgm_n) begin
            mode = MD_ILLEGAL;
        end else begin
            mode = vpp_hi ? MD_VERIFY : MD_READ;
        end
    end

    // Output drive and identification-code qualification.
    always_comb begin
        drive  = mode_drives(mode);
        id_sel = id_hv && (mode == MD_READ) && ((addr & QUAL_MASK) == '0);
    end

endmodule

// File: rtl/eprom_strobe_det.sv
// Module: eprom_strobe_det
// Detects the falling edge of the active-low program strobe, one cycle wide.
// Assumes: strobe is synchronous; reset state treats the strobe as idle high.
module eprom_strobe_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pgm_n,
    output logic fall
);

    logic pgm_q;

    // Remember last sampled strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pgm_q <= 1'b1;
        end else begin
            pgm_q <= pgm_n;
        end
    end

    // Edge is high-then-low between consecutive samples.
    always_comb begin
        fall = pgm_q && !pgm_n;
    end

endmodule

// File: rtl/eprom_erase_sweep.sv
// Module: eprom_erase_sweep
// Walks every address once, requesting an all-ones write for each. Runs
// after reset and on each accepted request.
// Assumes: requests while busy are ignored; depth is a power of two.
module eprom_erase_sweep #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              we,
    output logic [ADDR_W-1:0] waddr
);

    logic              busy_q;
    logic [ADDR_W-1:0] cnt_q;

    // Sweep state: reset begins a sweep at address zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            cnt_q <= cnt_q + ADDR_W'(1);
            if (&cnt_q) begin
                busy_q <= 1'b0;
            end
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end
    end

    // Write strobe and address for the array.
    always_comb begin
        busy  = busy_q;
        we    = busy_q && rst_n;
        waddr = cnt_q;
    end

endmodule

// File: rtl/eprom_model.sv
// Module: eprom_model (top)
// Clocked model of a programmable byte memory that can only clear bits. It
// has six pin modes, a sweep erase and an identification-code readout.
// Assumes: all pins synchronous to clk; outputs registered, one cycle latency.
module eprom_model
    import eprom_pkg::*;
#(
    parameter int              ADDR_W   = 11,
    parameter int              DATA_W   = 8,
    parameter int              ID_BIT   = 9,
    parameter logic [DATA_W-1:0] MFR_CODE = DATA_W'(8'h8F),
    parameter logic [DATA_W-1:0] DEV_CODE = DATA_W'(8'hC2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              pgm_n,
    input  logic [DATA_W-1:0] din,
    input  logic              vpp_hi,
    input  logic              id_hv,
    input  logic              erase_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe,
    output logic              busy,
    output logic              prog_err
);

    localparam int DEPTH = 1 << ADDR_W;

    eprom_mode_e       mode;
    logic              drive;
    logic              id_sel;
    logic              strobe_fall;
    logic              sweep_busy;
    logic              sweep_we;
    logic [ADDR_W-1:0] sweep_addr;
    logic              prog_we;
    logic              err_hit;
    logic [DATA_W-1:0] id_byte;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_data_q;
    logic              rd_oe_q;
    logic              prog_err_q;

    eprom_mode_dec #(
        .ADDR_W (ADDR_W),
        .ID_BIT (ID_BIT)
    ) u_dec (
        .addr   (addr),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .pgm_n  (pgm_n),
        .vpp_hi (vpp_hi),
        .id_hv  (id_hv),
        .mode   (mode),
        .drive  (drive),
        .id_sel (id_sel)
    );

    eprom_strobe_det u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .pgm_n (pgm_n),
        .fall  (strobe_fall)
    );

    eprom_erase_sweep #(
        .ADDR_W (ADDR_W)
    ) u_sweep (
        .clk   (clk),
        .rst_n (rst_n),
        .start (erase_req),
        .busy  (sweep_busy),
        .we    (sweep_we),
        .waddr (sweep_addr)
    );

    // Write qualification and programming-error detection.
    always_comb begin
        prog_we = strobe_fall && (mode == MD_PROGRAM) && !sweep_busy;
        err_hit = strobe_fall && !ce_n && !vpp_hi;
        id_byte = addr[0] ? DEV_CODE : MFR_CODE;
    end

    // Array write port: the erase sweep wins, otherwise program clears bits.
    always_ff @(posedge clk) begin
        if (sweep_we) begin
            mem[sweep_addr] <= '1;
        end else if (prog_we) begin
            mem[addr] <= mem[addr] & din;
        end
    end

    // Registered output stage and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q  <= '0;
            rd_oe_q    <= 1'b0;
            prog_err_q <= 1'b0;
        end else begin
            rd_oe_q    <= drive;
            rd_data_q  <= drive ? (id_sel ? id_byte : mem[addr]) : '0;
            prog_err_q <= err_hit;
        end
    end

    // Port mapping.
    always_comb begin
        rd_data  = rd_data_q;
        rd_oe    = rd_oe_q;
        busy     = sweep_busy;
        prog_err = prog_err_q;
    end

endmodule

// File: rtl/eprom_model_chk.sv
// Module: eprom_model_chk
// Port-level temporal checks for eprom_model. It is bound to every instance.
// Assumes: pgm_n is high during reset; pins are synchronous to clk.
module eprom_model_chk #(
    parameter int              ADDR_W   = 11,
    parameter int              DATA_W   = 8,
    parameter int              ID_BIT   = 9,
    parameter logic [DATA_W-1:0] MFR_CODE = DATA_W'(8'h8F),
    parameter logic [DATA_W-1:0] DEV_CODE = DATA_W'(8'hC2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ce_n,
    input logic              oe_n,
    input logic              pgm_n,
    input logic              vpp_hi,
    input logic              id_hv,
    input logic              erase_req,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_oe,
    input logic              busy,
    input logic              prog_err
);

    localparam logic [ADDR_W-1:0] OTHER_BITS =
        ~((ADDR_W'(1) << ID_BIT) | ADDR_W'(1));

    AST_STANDBY_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !rd_oe); // R5

    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_oe |-> rd_data == '0); // R5

    AST_DISABLE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n && !vpp_hi) |=> !rd_oe); // R6

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && pgm_n) |=> rd_oe); // R4

    AST_ID_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (id_hv && !ce_n && !oe_n && pgm_n && !vpp_hi && ((addr & OTHER_BITS) == '0))
        |=> (rd_data == ($past(addr[0]) ? DEV_CODE : MFR_CODE))); // R8

    AST_ERR_ON_BAD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pgm_n) && !ce_n && !vpp_hi) |=> prog_err); // R9

    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_err |-> ($past(!vpp_hi) && $past(!ce_n) && $past(!pgm_n))); // R9

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_err |=> !prog_err); // R9

    AST_ERASE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !busy) |=> busy); // R10

endmodule

bind eprom_model eprom_model_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .ID_BIT   (ID_BIT),
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .pgm_n     (pgm_n),
    .vpp_hi    (vpp_hi),
    .id_hv     (id_hv),
    .erase_req (erase_req),
    .rd_data   (rd_data),
    .rd_oe     (rd_oe),
    .busy      (busy),
    .prog_err  (prog_err)
);

// File: tb/eprom_model_test.sv
// Bench: exhaustive address sweeps over a 1024-byte configuration. Expected
// bytes come from the write patterns combined arithmetically.
`timescale 1ns/1ps
module eprom_model_test;

    localparam int AW    = 10;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ce_n, oe_n, pgm_n, vpp_hi, id_hv, erase_req;
    logic [DW-1:0] din;
    logic [DW-1:0] rd_data;
    logic          rd_oe, busy, prog_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    eprom_model #(.ADDR_W(AW), .DATA_W(DW), .ID_BIT(9)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
        .pgm_n(pgm_n), .din(din), .vpp_hi(vpp_hi), .id_hv(id_hv),
        .erase_req(erase_req), .rd_data(rd_data), .rd_oe(rd_oe),
        .busy(busy), .prog_err(prog_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat_a(input int a);
        return 8'((a * 37 + 11) & 8'hFF);
    endfunction

    function automatic logic [7:0] pat_b(input int a);
        return 8'(((a * 13 + 7) ^ 8'hA5) & 8'hFF);
    endfunction

    task automatic idle();
        ce_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b1;
        vpp_hi = 1'b0; id_hv = 1'b0; erase_req = 1'b0;
    endtask

    task automatic rd(input int a, input logic vpp, input logic idf,
                      output logic oe, output logic [7:0] d);
        @(negedge clk);
        addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0; pgm_n = 1'b1;
        vpp_hi = vpp; id_hv = idf;
        @(negedge clk);
        oe = rd_oe; d = rd_data;
        idle();
    endtask

    task automatic prog(input int a, input logic [7:0] d, input logic vpp,
                        input logic ce, output logic err);
        @(negedge clk);
        addr = AW'(a); din = d; ce_n = ce; oe_n = 1'b1; pgm_n = 1'b1; vpp_hi = vpp;
        @(negedge clk);
        pgm_n = 1'b0;
        @(negedge clk);
        err = prog_err;
        pgm_n = 1'b1;
        @(negedge clk);
        chk("R9 pulse width", 32'(prog_err), 32'd0);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic       oe, e;
        logic [7:0] d;
        int         n;
        idle();
        addr = '0; din = '0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset busy", 32'(busy), 32'd1);
        chk("R1 reset rd_oe", 32'(rd_oe), 32'd0);
        chk("R1 reset rd_data", 32'(rd_data), 32'd0);
        chk("R1 reset prog_err", 32'(prog_err), 32'd0);
        rst_n = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (busy && n < 3 * DEPTH);
        chk("R1 sweep length", 32'(n), 32'(DEPTH));
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, 1'b0, 1'b0, oe, d);
            chk("R1 erased byte", 32'(d), 32'hFF);
        end

        // R2: two programming passes; result is the AND of both patterns.
        for (int a = 0; a < DEPTH; a++) prog(a, pat_a(a), 1'b1, 1'b0, e);
        for (int a = 0; a < DEPTH; a++) prog(a, pat_b(a), 1'b1, 1'b0, e);
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, 1'b0, 1'b0, oe, d);
            chk("R2 and-programmed", 32'(d), 32'(pat_a(a) & pat_b(a)));
        end
        prog(4, 8'hFF, 1'b1, 1'b0, e);
        rd(4, 1'b0, 1'b0, oe, d);
        chk("R2 ones cannot set", 32'(d), 32'(pat_a(4) & pat_b(4)));

        // R4: read and verify both drive the stored byte.
        rd(17, 1'b0, 1'b0, oe, d);
        chk("R4 read oe", 32'(oe), 32'd1);
        rd(17, 1'b1, 1'b0, oe, d);
        chk("R4 verify oe", 32'(oe), 32'd1);
        chk("R4 verify data", 32'(d), 32'(pat_a(17) & pat_b(17)));

        // R3: held strobe with changing data writes only once.
        @(negedge clk);
        addr = AW'(9); din = 8'hFF; ce_n = 1'b0; oe_n = 1'b1; vpp_hi = 1'b1;
        @(negedge clk); pgm_n = 1'b0;
        for (int i = 0; i < 4; i++) begin @(negedge clk); din = 8'h00; end
        pgm_n = 1'b1; idle();
        rd(9, 1'b0, 1'b0, oe, d);
        chk("R3 held strobe", 32'(d), 32'(pat_a(9) & pat_b(9)));

        // R5: standby floats regardless of oe_n and vpp_hi.
        @(negedge clk); addr = AW'(17); ce_n = 1'b1; oe_n = 1'b0; vpp_hi = 1'b0;
        @(negedge clk);
        chk("R5 standby oe", 32'(rd_oe), 32'd0);
        chk("R5 standby data", 32'(rd_data), 32'd0);
        vpp_hi = 1'b1;
        @(negedge clk);
        chk("R5 standby vpp oe", 32'(rd_oe), 32'd0);
        idle();

        // R6: output disable.
        @(negedge clk); addr = AW'(17); ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        chk("R6 disable oe", 32'(rd_oe), 32'd0);
        idle();

        // R7: program inhibit with ce_n high.
        prog(10, 8'h00, 1'b1, 1'b1, e);
        rd(10, 1'b0, 1'b0, oe, d);
        chk("R7 inhibit", 32'(d), 32'(pat_a(10) & pat_b(10)));

        // R8: identification bytes; bit 9 value itself is ignored.
        rd(0, 1'b0, 1'b1, oe, d);
        chk("R8 maker code", 32'(d), 32'h8F);
        rd(1, 1'b0, 1'b1, oe, d);
        chk("R8 device code", 32'(d), 32'hC2);
        rd(1 | (1 << 9), 1'b0, 1'b1, oe, d);
        chk("R8 device code bit9 set", 32'(d), 32'hC2);
        rd(8, 1'b0, 1'b1, oe, d);
        chk("R8 other bit set gives array", 32'(d), 32'(pat_a(8) & pat_b(8)));

        // R9: strobe without programming supply.
        prog(12, 8'h00, 1'b0, 1'b0, e);
        chk("R9 error pulse", 32'(e), 32'd1);
        rd(12, 1'b0, 1'b0, oe, d);
        chk("R9 no write", 32'(d), 32'(pat_a(12) & pat_b(12)));

        // R10: requested erase; a strobe on address 0 mid-sweep is dropped.
        @(negedge clk); erase_req = 1'b1;
        @(negedge clk); erase_req = 1'b0;
        n = 0;
        while (busy && n < 3 * DEPTH) begin
            n++;
            if (n == 5) begin
                addr = '0; din = 8'h00; ce_n = 1'b0; oe_n = 1'b1; vpp_hi = 1'b1;
            end
            if (n == 6) pgm_n = 1'b0;
            if (n == 7) begin pgm_n = 1'b1; idle(); end
            @(negedge clk);
        end
        chk("R10 busy length", 32'(n), 32'(DEPTH));
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, 1'b0, 1'b0, oe, d);
            chk("R10 erased byte", 32'(d), 32'hFF);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule